// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block owns the general-exception state of a simple 32-bit processor core. It does not decode instructions. When the core raises an exception request, the request carries the faulting PC, a cause code and, if it has one, a faulting virtual address. In the next cycle the block updates its saved-PC, double-exception-PC, cause, faulting-address and status registers. It also emits a one-cycle redirect that carries the vector address where fetch must resume.

The block tells a double exception apart from a first-level exception by the exception-mode bit of the status word. For a first-level exception, the user-mode bit of the status word chooses between the user vector and the kernel vector. A configuration parameter decides whether a double exception saves its PC in a dedicated register or in the normal saved-PC register.

The block also carries out the two exception-return operations, and each one produces a redirect to the saved return address. The core can load the status word directly through a write port. After reset, the block issues one redirect to the reset vector. All vector addresses are parameters.

Top module: `exc_dispatch`

## Requirements
- R1: While reset is held, the status word reads 0x0000001f and the saved PC, double-exception PC, cause and faulting-address registers read 0. In the first cycle after reset is released, one redirect to RESET_VEC is issued.
- R2: An exception request taken while status bit 4 (exception mode) and status bit 5 (user mode) are both 0 stores the faulting PC in the saved-PC register and redirects to KERNEL_VEC in the next cycle.
- R3: An exception request taken while status bit 4 is 0 and status bit 5 is 1 stores the faulting PC in the saved-PC register and redirects to USER_VEC.
- R4: An exception request taken while status bit 4 is 1 is a double exception. It redirects to DOUBLE_VEC. With HAS_DEPC=1 the faulting PC goes to the double-exception-PC register and the saved-PC register keeps its value; with HAS_DEPC=0 the faulting PC goes to the saved-PC register.
- R5: Every exception stores its 6-bit cause code and sets status bit 4, and leaves every other status bit unchanged. The defined codes are: illegal instruction 0, syscall 1, privileged 8, alignment 9, instruction TLB miss 16, data TLB miss 24, load prohibited 28, store prohibited 29, coprocessor 0 disabled 32.
- R6: The faulting-address register is written only by an exception whose address-valid input is 1. Otherwise it holds its value.
- R7: The normal return clears status bit 4, leaves the other status bits unchanged, and redirects to the saved-PC register.
- R8: The double return redirects to the double-exception-PC register (HAS_DEPC=1) or to the saved-PC register (HAS_DEPC=0), and leaves the status word unchanged.
- R9: The redirect valid is high for exactly one cycle per exception, return or reset release, and is low in every other cycle. Requests on back-to-back cycles give back-to-back redirects.
- R10: A status write loads the whole status word in the next cycle and issues no redirect.
- R11: At most one of exception request, normal return, double return and status write is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_cause | input | 6 | Cause code |
| exc_vaddr_vld | input | 1 | Faulting address present with the request |
| exc_vaddr | input | 32 | Faulting virtual address |
| ret_norm | input | 1 | Return from first-level exception |
| ret_dbl | input | 1 | Return from double exception |
| ps_wr | input | 1 | Status word write strobe |
| ps_wdata | input | 32 | Status word write data |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target address |
| ps_q | output | 32 | Status word |
| epc_q | output | 32 | Saved PC |
| depc_q | output | 32 | Double-exception PC |
| cause_q | output | 6 | Last cause code |
| vaddr_q | output | 32 | Last faulting address |

## Verification
The assertions assume that the core never raises more than one of the four operation inputs in a cycle. They also assume it makes no request in the cycle right after reset release, when the reset redirect has priority. The stimulus issues each operation through its own task, which raises a single strobe for one cycle, and stays idle through the reset-release cycle. Back-to-back exceptions are still driven on consecutive cycles by separate strobes. This run checks that the second exception sees the exception-mode bit set by the first one.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception dispatch unit.
// Assumes a status word in which bit 4 is exception mode and bit 5 is user mode.
package exc_pkg;
    localparam int EXCM_BIT = 4;
    localparam int UM_BIT   = 5;
    localparam int CAUSE_W  = 6;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_ILLEGAL    = 6'd0,
        CAUSE_SYSCALL    = 6'd1,
        CAUSE_PRIV       = 6'd8,
        CAUSE_ALIGN      = 6'd9,
        CAUSE_ITLB_MISS  = 6'd16,
        CAUSE_DTLB_MISS  = 6'd24,
        CAUSE_LD_PROHIB  = 6'd28,
        CAUSE_ST_PROHIB  = 6'd29,
        CAUSE_CP0_DIS    = 6'd32
    } exc_cause_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EXC,
        OP_RET_NORM,
        OP_RET_DBL,
        OP_PS_WR
    } exc_op_e;
endpackage

// File: rtl/exc_route.sv
// Combinational decision logic: picks the operation of the cycle, the register
// write enables, the next status word and the redirect target.
// Assumes at most one operation strobe per cycle; a fixed priority resolves any overlap.
module exc_route
    import exc_pkg::*;
#(
    parameter int          W          = 32,
    parameter bit          HAS_DEPC   = 1'b1,
    parameter logic [31:0] KERNEL_VEC = 32'h5fff861c,
    parameter logic [31:0] USER_VEC   = 32'h5fff863c,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff865c
) (
    input  logic         exc_req,
    input  logic         exc_vaddr_vld,
    input  logic         ret_norm,
    input  logic         ret_dbl,
    input  logic         ps_wr,
    input  logic [W-1:0] ps_wdata,
    input  logic [W-1:0] cur_ps,
    input  logic [W-1:0] cur_epc,
    input  logic [W-1:0] cur_depc,
    output logic         epc_we,
    output logic         depc_we,
    output logic         cause_we,
    output logic         vaddr_we,
    output logic         ps_we,
    output logic [W-1:0] ps_nxt,
    output logic         tgt_vld,
    output logic [W-1:0] tgt_pc
);
    localparam logic [W-1:0] EXCM_MASK = W'(1) << EXCM_BIT;

    exc_op_e op;

    // Select the operation of this cycle by fixed priority.
    always_comb begin
        if (exc_req)       op = OP_EXC;
        else if (ret_norm) op = OP_RET_NORM;
        else if (ret_dbl)  op = OP_RET_DBL;
        else if (ps_wr)    op = OP_PS_WR;
        else               op = OP_NONE;
    end

    // Derive write enables, next status and redirect target from the operation.
    always_comb begin
        epc_we   = 1'b0;
        depc_we  = 1'b0;
        cause_we = 1'b0;
        vaddr_we = 1'b0;
        ps_we    = 1'b0;
        ps_nxt   = cur_ps;
        tgt_vld  = 1'b0;
        tgt_pc   = '0;
        case (op)
            OP_EXC: begin
                if (cur_ps[EXCM_BIT]) begin
                    tgt_pc = W'(DOUBLE_VEC);
                    if (HAS_DEPC) depc_we = 1'b1;
                    else          epc_we  = 1'b1;
                end else begin
                    epc_we = 1'b1;
                    tgt_pc = cur_ps[UM_BIT] ? W'(USER_VEC) : W'(KERNEL_VEC);
                end
                cause_we = 1'b1;
                vaddr_we = exc_vaddr_vld;
                ps_we    = 1'b1;
                ps_nxt   = cur_ps | EXCM_MASK;
                tgt_vld  = 1'b1;
            end
            OP_RET_NORM: begin
                ps_we   = 1'b1;
                ps_nxt  = cur_ps & ~EXCM_MASK;
                tgt_vld = 1'b1;
                tgt_pc  = cur_epc;
            end
            OP_RET_DBL: begin
                tgt_vld = 1'b1;
                tgt_pc  = HAS_DEPC ? cur_depc : cur_epc;
            end
            OP_PS_WR: begin
                ps_we  = 1'b1;
                ps_nxt = ps_wdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_state_regs.sv
// Exception state storage: status, saved PC, double-exception PC, cause, faulting address.
// Assumes the write enables are already decoded; the double-exception PC register
// exists only when HAS_DEPC is set, and reads 0 otherwise.
module exc_state_regs #(
    parameter int          W        = 32,
    parameter int          CW       = 6,
    parameter bit          HAS_DEPC = 1'b1,
    parameter logic [31:0] PS_RST   = 32'h0000001f
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epc_we,
    input  logic          depc_we,
    input  logic          cause_we,
    input  logic          vaddr_we,
    input  logic          ps_we,
    input  logic [W-1:0]  ps_nxt,
    input  logic [W-1:0]  pc_in,
    input  logic [CW-1:0] cause_in,
    input  logic [W-1:0]  vaddr_in,
    output logic [W-1:0]  ps_q,
    output logic [W-1:0]  epc_q,
    output logic [W-1:0]  depc_q,
    output logic [CW-1:0] cause_q,
    output logic [W-1:0]  vaddr_q
);
    // Hold the status word, saved PC, cause and faulting address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= W'(PS_RST);
            epc_q   <= '0;
            cause_q <= '0;
            vaddr_q <= '0;
        end else begin
            if (ps_we)    ps_q    <= ps_nxt;
            if (epc_we)   epc_q   <= pc_in;
            if (cause_we) cause_q <= cause_in;
            if (vaddr_we) vaddr_q <= vaddr_in;
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            // Hold the double-exception PC.
            always_ff @(posedge clk) begin
                if (!rst_n)       depc_q <= '0;
                else if (depc_we) depc_q <= pc_in;
            end
        end else begin : g_no_depc
            assign depc_q = '0;
        end
    endgenerate
endmodule

// File: rtl/exc_redirect.sv
// Redirect output stage: registers the target into a one-cycle pulse and
// issues the reset-vector redirect in the first cycle after reset release.
// Assumes no operation arrives in that first cycle; the reset redirect wins.
module exc_redirect #(
    parameter int          W         = 32,
    parameter logic [31:0] RESET_VEC = 32'h5fff8000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgt_vld,
    input  logic [W-1:0] tgt_pc,
    output logic         redir_vld,
    output logic [W-1:0] redir_pc
);
    logic boot_q;

    // Register the redirect, with the reset vector first after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q    <= 1'b1;
            redir_vld <= 1'b0;
            redir_pc  <= '0;
        end else begin
            boot_q    <= 1'b0;
            redir_vld <= boot_q | tgt_vld;
            redir_pc  <= boot_q ? W'(RESET_VEC) : tgt_pc;
        end
    end
endmodule

// File: rtl/exc_dispatch.sv
// Exception dispatch top: connects the decision logic, the state registers and
// the redirect stage. Assumes one operation strobe per cycle.
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int          W          = 32,
    parameter bit          HAS_DEPC   = 1'b1,
    parameter logic [31:0] RESET_VEC  = 32'h5fff8000,
    parameter logic [31:0] KERNEL_VEC = 32'h5fff861c,
    parameter logic [31:0] USER_VEC   = 32'h5fff863c,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff865c,
    parameter logic [31:0] PS_RST     = 32'h0000001f
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [W-1:0]       exc_pc,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_vaddr_vld,
    input  logic [W-1:0]       exc_vaddr,
    input  logic               ret_norm,
    input  logic               ret_dbl,
    input  logic               ps_wr,
    input  logic [W-1:0]       ps_wdata,
    output logic               redir_vld,
    output logic [W-1:0]       redir_pc,
    output logic [W-1:0]       ps_q,
    output logic [W-1:0]       epc_q,
    output logic [W-1:0]       depc_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [W-1:0]       vaddr_q
);
    logic         epc_we, depc_we, cause_we, vaddr_we, ps_we, tgt_vld;
    logic [W-1:0] ps_nxt, tgt_pc;

    exc_route #(
        .W(W), .HAS_DEPC(HAS_DEPC),
        .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC)
    ) u_route (
        .exc_req(exc_req), .exc_vaddr_vld(exc_vaddr_vld),
        .ret_norm(ret_norm), .ret_dbl(ret_dbl),
        .ps_wr(ps_wr), .ps_wdata(ps_wdata),
        .cur_ps(ps_q), .cur_epc(epc_q), .cur_depc(depc_q),
        .epc_we(epc_we), .depc_we(depc_we), .cause_we(cause_we),
        .vaddr_we(vaddr_we), .ps_we(ps_we), .ps_nxt(ps_nxt),
        .tgt_vld(tgt_vld), .tgt_pc(tgt_pc)
    );

    exc_state_regs #(
        .W(W), .CW(CAUSE_W), .HAS_DEPC(HAS_DEPC), .PS_RST(PS_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .epc_we(epc_we), .depc_we(depc_we), .cause_we(cause_we),
        .vaddr_we(vaddr_we), .ps_we(ps_we), .ps_nxt(ps_nxt),
        .pc_in(exc_pc), .cause_in(exc_cause), .vaddr_in(exc_vaddr),
        .ps_q(ps_q), .epc_q(epc_q), .depc_q(depc_q),
        .cause_q(cause_q), .vaddr_q(vaddr_q)
    );

    exc_redirect #(.W(W), .RESET_VEC(RESET_VEC)) u_redir (
        .clk(clk), .rst_n(rst_n),
        .tgt_vld(tgt_vld), .tgt_pc(tgt_pc),
        .redir_vld(redir_vld), .redir_pc(redir_pc)
    );
endmodule

// File: rtl/exc_dispatch_chk.sv
// Property checker for the exception dispatch unit, attached by bind.
// Assumes the default status bit layout of the package.
module exc_dispatch_chk
    import exc_pkg::*;
#(
    parameter int          W          = 32,
    parameter logic [31:0] KERNEL_VEC = 32'h5fff861c,
    parameter logic [31:0] USER_VEC   = 32'h5fff863c,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff865c
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exc_req,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic               exc_vaddr_vld,
    input logic               ret_norm,
    input logic               ret_dbl,
    input logic               ps_wr,
    input logic               redir_vld,
    input logic [W-1:0]       redir_pc,
    input logic [W-1:0]       ps_q,
    input logic [W-1:0]       epc_q,
    input logic [CAUSE_W-1:0] cause_q,
    input logic [W-1:0]       vaddr_q
);
    logic any_op;
    assign any_op = exc_req | ret_norm | ret_dbl | ps_wr;

    assert_one_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({exc_req, ret_norm, ret_dbl, ps_wr}) <= 1);

    assert_kernel_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !ps_q[EXCM_BIT] && !ps_q[UM_BIT] |=> redir_vld && redir_pc == W'(KERNEL_VEC));

    assert_user_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !ps_q[EXCM_BIT] && ps_q[UM_BIT] |=> redir_vld && redir_pc == W'(USER_VEC));

    assert_double_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && ps_q[EXCM_BIT] |=> redir_vld && redir_pc == W'(DOUBLE_VEC));

    assert_excm_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> ps_q[EXCM_BIT] && cause_q == $past(exc_cause));

    assert_vaddr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req && exc_vaddr_vld) |=> $stable(vaddr_q));

    assert_ret_norm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_norm && !exc_req |=> !ps_q[EXCM_BIT] && redir_vld && redir_pc == $past(epc_q));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !any_op |=> !redir_vld);
endmodule

bind exc_dispatch exc_dispatch_chk #(
    .W(W), .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_vaddr_vld(exc_vaddr_vld), .ret_norm(ret_norm), .ret_dbl(ret_dbl),
    .ps_wr(ps_wr), .redir_vld(redir_vld), .redir_pc(redir_pc), .ps_q(ps_q),
    .epc_q(epc_q), .cause_q(cause_q), .vaddr_q(vaddr_q)
);

// File: tb/exc_dispatch_tb.sv
// Scoreboard bench: driver tasks queue the expected redirect targets, and a
// monitor pops them as redirect pulses appear.
module exc_dispatch_tb;
    import exc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RV = 32'h5fff8000;
    localparam logic [31:0] KV = 32'h5fff861c;
    localparam logic [31:0] UV = 32'h5fff863c;
    localparam logic [31:0] DV = 32'h5fff865c;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 1'b0, exc_vaddr_vld = 1'b0, ret_norm = 1'b0, ret_dbl = 1'b0, ps_wr = 1'b0;
    logic [31:0] exc_pc = '0, exc_vaddr = '0, ps_wdata = '0;
    logic [5:0]  exc_cause = '0;
    logic        redir_vld;
    logic [31:0] redir_pc, ps_q, epc_q, depc_q, vaddr_q;
    logic [5:0]  cause_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];

    exc_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_pc(exc_pc),
        .exc_cause(exc_cause), .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr),
        .ret_norm(ret_norm), .ret_dbl(ret_dbl), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
        .redir_vld(redir_vld), .redir_pc(redir_pc), .ps_q(ps_q), .epc_q(epc_q),
        .depc_q(depc_q), .cause_q(cause_q), .vaddr_q(vaddr_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: every redirect pulse must match the head of the queue (R9).
    always @(negedge clk) begin
        if (rst_n && redir_vld) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected redirect actual=%08h expected=none", redir_pc);
            end else begin
                chk("R9 redirect target", redir_pc, exp_q.pop_front());
            end
        end
    end

    task automatic clear_inputs();
        exc_req = 1'b0; exc_vaddr_vld = 1'b0; ret_norm = 1'b0; ret_dbl = 1'b0; ps_wr = 1'b0;
    endtask

    task automatic do_exc(input logic [31:0] pc, input logic [5:0] cause,
                          input logic vv, input logic [31:0] va, input logic [31:0] vec);
        exc_req = 1'b1; exc_pc = pc; exc_cause = cause; exc_vaddr_vld = vv; exc_vaddr = va;
        exp_q.push_back(vec);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_ret_norm(input logic [31:0] tgt);
        ret_norm = 1'b1;
        exp_q.push_back(tgt);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_ret_dbl(input logic [31:0] tgt);
        ret_dbl = 1'b1;
        exp_q.push_back(tgt);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_ps_wr(input logic [31:0] v);
        ps_wr = 1'b1; ps_wdata = v;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", ps_q, 32'h1f);
        chk("R1 reset epc", epc_q, 0);
        chk("R1 reset depc", depc_q, 0);
        chk("R1 reset cause", {26'd0, cause_q}, 0);
        chk("R1 reset vaddr", vaddr_q, 0);
        exp_q.push_back(RV);              // R1 reset-vector redirect
        rst_n = 1'b1;
        idle(2);

        // R4: exception mode is set out of reset, so this is a double exception.
        do_exc(32'h100, CAUSE_ILLEGAL, 1'b0, 0, DV);
        chk("R4 depc", depc_q, 32'h100);
        chk("R4 epc unchanged", epc_q, 0);
        chk("R5 cause illegal", {26'd0, cause_q}, CAUSE_ILLEGAL);

        do_ret_dbl(32'h100);              // R8
        chk("R8 status unchanged", ps_q, 32'h1f);

        do_ret_norm(32'h0);               // R7
        chk("R7 exception mode cleared", ps_q, 32'h0f);

        // R2: kernel exception.
        do_exc(32'h200, CAUSE_SYSCALL, 1'b0, 0, KV);
        chk("R2 epc", epc_q, 32'h200);
        chk("R5 status sets bit 4 only", ps_q, 32'h1f);
        chk("R5 cause syscall", {26'd0, cause_q}, CAUSE_SYSCALL);

        do_ps_wr(32'h20);                 // R10, no redirect expected
        chk("R10 status write", ps_q, 32'h20);

        // R3 and R6: user exception with faulting address.
        do_exc(32'h300, CAUSE_LD_PROHIB, 1'b1, 32'hdeadbeef, UV);
        chk("R3 epc", epc_q, 32'h300);
        chk("R6 vaddr written", vaddr_q, 32'hdeadbeef);
        chk("R5 status user", ps_q, 32'h30);
        chk("R5 cause load prohibited", {26'd0, cause_q}, CAUSE_LD_PROHIB);

        // R6: double exception without address keeps vaddr.
        do_exc(32'h400, CAUSE_ALIGN, 1'b0, 32'h12345678, DV);
        chk("R6 vaddr held", vaddr_q, 32'hdeadbeef);
        chk("R4 depc second", depc_q, 32'h400);
        chk("R4 epc kept", epc_q, 32'h300);

        do_ret_norm(32'h300);             // R7
        chk("R7 status back to user", ps_q, 32'h20);

        // R9: back-to-back exceptions; second one sees exception mode from the first.
        do_ps_wr(32'h0);
        do_exc(32'h500, CAUSE_DTLB_MISS, 1'b1, 32'h0000abcd, KV);
        do_exc(32'h600, CAUSE_CP0_DIS, 1'b0, 0, DV);
        chk("R9 epc after pair", epc_q, 32'h500);
        chk("R9 depc after pair", depc_q, 32'h600);
        chk("R5 cause coprocessor", {26'd0, cause_q}, CAUSE_CP0_DIS);
        chk("R6 vaddr from pair", vaddr_q, 32'h0000abcd);

        idle(4);
        chk("R9 no pending redirects", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule